// File: doc/BRIEF.md
# PHY Channel Ownership Arbiter

This block decides which of two PHY functions drives each shared channel and keeps the 32-bit select word that steers the channel multiplexers. Several requesters send claim or release requests, each naming a channel and a PHY number. The first claim on a free channel takes ownership and writes that channel's select field. Later claims on the same channel get a busy answer until the channel is released.

Every request gets a registered response one cycle later: grant, busy or error. A granted claim changes only its own channel's field in the select word and keeps every other bit. A release frees the channel and leaves the select word as it is, so the multiplexer holds its last setting. The parameter `VARIANT` picks the channel map. Variant 0 has channels 0 and 2. Variant 1 has channel 0 only, with different PHY encodings.

Top module: `phy_chan_arb`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `sel_word` is zero, `rsp_valid` is all zero and every channel is unowned.
- R2: A claim on a known, unowned channel with PHY 0 or 1 returns code 2'b00 (grant) in the next cycle, and the channel becomes owned.
- R3: A claim on an owned channel returns code 2'b01 (busy) and does not change `sel_word`.
- R4: In variant 0, a granted claim on channel 0 writes bits [5:4] with 2'b01 for PHY 0 and 2'b11 for PHY 1.
- R5: In variant 0, a granted claim on channel 2 writes bit 31 with 0 for PHY 0 and 1 for PHY 1.
- R6: In variant 1, only channel 0 exists. PHY 0 writes 2'b01 and PHY 1 writes 2'b10 into bits [5:4]. Any request on another channel returns error.
- R7: A granted claim first clears its channel's field, then writes the new value. All other bits of `sel_word` keep their value, and no bit outside the known fields is ever set.
- R8: A claim with PHY number 2 or 3, or any request on an unknown channel (1 or 3 in variant 0), returns code 2'b10 (error) and changes neither ownership nor `sel_word`. A release ignores the PHY number.
- R9: A release on a known channel returns grant, marks the channel unowned and leaves `sel_word` unchanged.
- R10: Requests in the same cycle take effect in ascending requester index, and each one sees the effect of the lower-indexed ones. Of two claims on one free channel, the lower index gets grant and the higher gets busy. A release followed by a claim on the same channel grants the claim.
- R11: `rsp_valid[i]` equals `req_valid[i]` from the previous cycle. `rsp_code[i]` is meaningful only when `rsp_valid[i]` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NREQ | Request present, one bit per requester |
| req_release | input | NREQ | 1 = release, 0 = claim |
| req_chan | input | NREQ x 2 | Channel index per requester |
| req_phy | input | NREQ x 2 | PHY number per requester |
| rsp_valid | output | NREQ | Response present, one cycle after the request |
| rsp_code | output | NREQ x 2 | 00 grant, 01 busy, 10 error |
| sel_word | output | 32 | Mux select word |

## Verification
The bench aims at same-cycle contention, because a design that resolved requesters in parallel and not in order would grant two owners of one channel, or reject a claim that follows a release in the same cycle. It writes one channel while the other channel's field is set. A read-modify-write that used a whole-word mask or a wrong field would then wipe bit 31 or bits [5:4]. Illegal PHY numbers and unknown channels are sent while a channel is owned and while one is free. A design that took them as legal would change ownership or set stray bits. A release is checked by looking at `sel_word` and then at the next claim. A design that cleared the field on release, or never freed the owner, would fail one of those two.

// File: rtl/phy_arb_pkg.sv
package phy_arb_pkg;
  localparam int REG_W = 32;
  localparam int SLOTS = 2;

  typedef enum logic [1:0] {
    RSP_GRANT = 2'b00,
    RSP_BUSY  = 2'b01,
    RSP_ERR   = 2'b10
  } rsp_e;

  typedef struct packed {
    logic             known;
    logic             slot;
    logic [REG_W-1:0] mask;
    logic [REG_W-1:0] value;
  } dec_t;
endpackage

// File: rtl/phy_req_decode.sv
module phy_req_decode
  import phy_arb_pkg::*;
#(
  parameter int VARIANT = 0
) (
  input  logic       is_release,
  input  logic [1:0] chan,
  input  logic [1:0] phy,
  output dec_t       dec
);
  localparam logic [REG_W-1:0] CH0_MASK = 32'h0000_0030;
  localparam logic [REG_W-1:0] CH2_MASK = 32'h8000_0000;
  localparam logic [REG_W-1:0] CH0_P0   = 32'h0000_0010;
  localparam logic [REG_W-1:0] CH0_P1   = (VARIANT == 0) ? 32'h0000_0030 : 32'h0000_0020;
  localparam logic              HAS_CH2  = (VARIANT == 0);

  logic phy_ok;
  assign phy_ok = is_release || (phy[1] == 1'b0);

  always_comb begin
    dec = '0;
    case (chan)
      2'd0: begin
        dec.known = phy_ok;
        dec.slot  = 1'b0;
        dec.mask  = CH0_MASK;
        dec.value = phy[0] ? CH0_P1 : CH0_P0;
      end
      2'd2: begin
        dec.known = phy_ok && HAS_CH2;
        dec.slot  = 1'b1;
        dec.mask  = CH2_MASK;
        dec.value = phy[0] ? CH2_MASK : '0;
      end
      default: dec = '0;
    endcase
  end
endmodule

// File: rtl/phy_own_resolve.sv
module phy_own_resolve
  import phy_arb_pkg::*;
#(
  parameter int NREQ = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NREQ-1:0]             req_valid,
  input  logic [NREQ-1:0]             req_release,
  input  dec_t [NREQ-1:0]             dec,
  input  logic [SLOTS-1:0]            owned_q,
  input  logic [REG_W-1:0]            sel_q,
  output logic [SLOTS-1:0]            owned_d,
  output logic [REG_W-1:0]            sel_d,
  output logic [NREQ-1:0][1:0]        code_d
);
  logic [SLOTS-1:0][NREQ-1:0] claim_win;

  always_comb begin
    owned_d   = owned_q;
    sel_d     = sel_q;
    claim_win = '0;
    for (int i = 0; i < NREQ; i++) begin
      code_d[i] = RSP_GRANT;
      if (req_valid[i]) begin
        if (!dec[i].known) begin
          code_d[i] = RSP_ERR;
        end else if (req_release[i]) begin
          owned_d[dec[i].slot] = 1'b0;
        end else if (owned_d[dec[i].slot]) begin
          code_d[i] = RSP_BUSY;
        end else begin
          owned_d[dec[i].slot]      = 1'b1;
          claim_win[dec[i].slot][i] = 1'b1;
          sel_d = (sel_d & ~dec[i].mask) | dec[i].value;
        end
      end
    end
  end

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot_chk
      // R10: one channel can never take more than one winning claim per cycle
      p_one_winner_r10: assert property (@(posedge clk) disable iff (rst)
        $countones(claim_win[s]) <= 1);
      // R3: a channel already owned at cycle start cannot be claimed again
      p_owned_no_win_r3: assert property (@(posedge clk) disable iff (rst)
        owned_q[s] && !(|(req_valid & req_release)) |-> claim_win[s] == '0);
    end
  endgenerate
endmodule

// File: rtl/phy_chan_arb.sv
module phy_chan_arb
  import phy_arb_pkg::*;
#(
  parameter int NREQ    = 3,
  parameter int VARIANT = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NREQ-1:0]      req_valid,
  input  logic [NREQ-1:0]      req_release,
  input  logic [NREQ-1:0][1:0] req_chan,
  input  logic [NREQ-1:0][1:0] req_phy,
  output logic [NREQ-1:0]      rsp_valid,
  output logic [NREQ-1:0][1:0] rsp_code,
  output logic [REG_W-1:0]     sel_word
);
  localparam logic [REG_W-1:0] LEGAL_BITS =
    (VARIANT == 0) ? 32'h8000_0030 : 32'h0000_0030;

  dec_t [NREQ-1:0]      dec;
  logic [SLOTS-1:0]     owned_q, owned_d;
  logic [REG_W-1:0]     sel_d;
  logic [NREQ-1:0][1:0] code_d;

  generate
    for (genvar i = 0; i < NREQ; i++) begin : g_dec
      phy_req_decode #(.VARIANT(VARIANT)) u_dec (
        .is_release (req_release[i]),
        .chan       (req_chan[i]),
        .phy        (req_phy[i]),
        .dec        (dec[i])
      );
    end
  endgenerate

  phy_own_resolve #(.NREQ(NREQ)) u_res (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_release (req_release),
    .dec         (dec),
    .owned_q     (owned_q),
    .sel_q       (sel_word),
    .owned_d     (owned_d),
    .sel_d       (sel_d),
    .code_d      (code_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      owned_q   <= '0;
      sel_word  <= '0;
      rsp_valid <= '0;
      rsp_code  <= '0;
    end else begin
      owned_q   <= owned_d;
      sel_word  <= sel_d;
      rsp_valid <= req_valid;
      rsp_code  <= code_d;
    end
  end

  // R1: reset clears the select word, ownership and responses
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (sel_word == '0) && (rsp_valid == '0) && (owned_q == '0));
  // R11: a response follows each request by exactly one cycle
  p_rsp_follows_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rsp_valid == $past(req_valid));
  // R9: without any claim in a cycle the select word holds
  p_hold_no_claim_r9: assert property (@(posedge clk) disable iff (rst)
    !(|(req_valid & ~req_release)) |=> $stable(sel_word));
  // R7: no bit outside the known channel fields is ever set
  p_legal_bits_r7: assert property (@(posedge clk) disable iff (rst)
    (sel_word & ~LEGAL_BITS) == '0);
  // R8: error responses only appear on requests that were sent
  p_err_only_valid_r8: assert property (@(posedge clk) disable iff (rst)
    !(|req_valid) |=> rsp_valid == '0);
endmodule

// File: tb/phy_chan_arb_tb.sv
module phy_chan_arb_tb_top;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]      v, rl;
  logic [N-1:0][1:0] c, p;
  logic [N-1:0]      rv_s, rv_m;
  logic [N-1:0][1:0] rc_s, rc_m;
  logic [31:0]       sel_s, sel_m;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [1:0]        own_s, own_m;
  logic [31:0]       esel_s, esel_m;
  logic [N-1:0][1:0] ec_s, ec_m;
  logic [N-1:0]      ev;

  always #2 clk = ~clk;

  phy_chan_arb #(.NREQ(N), .VARIANT(0)) dut_i (
    .clk(clk), .rst(rst), .req_valid(v), .req_release(rl),
    .req_chan(c), .req_phy(p), .rsp_valid(rv_s), .rsp_code(rc_s),
    .sel_word(sel_s));

  phy_chan_arb #(.NREQ(N), .VARIANT(1)) dut_s_i (
    .clk(clk), .rst(rst), .req_valid(v), .req_release(rl),
    .req_chan(c), .req_phy(p), .rsp_valid(rv_m), .rsp_code(rc_m),
    .sel_word(sel_m));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string code_tag(input logic [1:0] cd);
    if (cd == 2'b00) return "R2";
    if (cd == 2'b01) return "R3";
    return "R8";
  endfunction

  task automatic model(input int vr, inout logic [1:0] own, inout logic [31:0] sel,
                       output logic [N-1:0][1:0] cd);
    for (int i = 0; i < N; i++) begin
      logic known, slot;
      logic [31:0] msk, val;
      cd[i] = 2'b00;
      known = 0; slot = 0; msk = 0; val = 0;
      if (c[i] == 2'd0) begin
        known = 1; slot = 0; msk = 32'h30;
        val = (p[i] == 2'd0) ? 32'h10 : (vr == 0 ? 32'h30 : 32'h20);
      end else if (c[i] == 2'd2 && vr == 0) begin
        known = 1; slot = 1; msk = 32'h8000_0000;
        val = (p[i] == 2'd1) ? 32'h8000_0000 : 32'h0;
      end
      if (!rl[i] && p[i] >= 2) known = 0;
      if (v[i]) begin
        if (!known) cd[i] = 2'b10;
        else if (rl[i]) own[slot] = 1'b0;
        else if (own[slot]) cd[i] = 2'b01;
        else begin
          own[slot] = 1'b1;
          sel = (sel & ~msk) | val;
        end
      end
    end
  endtask

  task automatic cycle();
    ev = v;
    model(0, own_s, esel_s, ec_s);
    model(1, own_m, esel_m, ec_m);
    @(posedge clk);
    @(negedge clk);
    check("R11 std valid", 32'(rv_s), 32'(ev));
    check("R11 simp valid", 32'(rv_m), 32'(ev));
    for (int i = 0; i < N; i++) begin
      if (ev[i]) begin
        check({code_tag(ec_s[i]), " std code"}, 32'(rc_s[i]), 32'(ec_s[i]));
        check({code_tag(ec_m[i]), " simp code"}, 32'(rc_m[i]), 32'(ec_m[i]));
      end
    end
    check("R7 std sel", sel_s, esel_s);
    check("R7 simp sel", sel_m, esel_m);
    v = '0; rl = '0; c = '0; p = '0;
  endtask

  task automatic set_req(input int i, input logic rel, input logic [1:0] ch, input logic [1:0] ph);
    v[i] = 1'b1; rl[i] = rel; c[i] = ch; p[i] = ph;
  endtask

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    v = '0; rl = '0; c = '0; p = '0;
    own_s = '0; own_m = '0; esel_s = '0; esel_m = '0;
    repeat (3) @(negedge clk);
    check("R1 sel in reset", sel_s, 32'h0);
    check("R1 valid in reset", 32'(rv_s), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 sel after reset", sel_s, 32'h0);
    check("R1 simp sel after reset", sel_m, 32'h0);

    // R10 contention, R4/R5 encodings, R6 simplified map
    set_req(0, 0, 2'd0, 2'd1); set_req(1, 0, 2'd0, 2'd1); set_req(2, 0, 2'd2, 2'd1);
    cycle();
    check("R10 lower index wins", 32'(rc_s[0]), 32'h0);
    check("R10 higher index busy", 32'(rc_s[1]), 32'h1);
    check("R4 R5 std fields", sel_s, 32'h8000_0030);
    check("R6 simp phy1 code", sel_m, 32'h0000_0020);
    check("R6 simp chan2 error", 32'(rc_m[2]), 32'h2);

    // R9 release keeps the word
    set_req(0, 1, 2'd0, 2'd3);
    cycle();
    check("R9 release grant", 32'(rc_s[0]), 32'h0);
    check("R9 sel kept", sel_s, 32'h8000_0030);

    // R4 phy0 and R7 preservation of bit 31
    set_req(1, 0, 2'd0, 2'd0);
    cycle();
    check("R4 std phy0 with bit31 kept", sel_s, 32'h8000_0010);
    check("R6 simp phy0", sel_m, 32'h0000_0010);

    // R8 illegal phy and unknown channels
    set_req(0, 0, 2'd0, 2'd2); set_req(1, 0, 2'd1, 2'd0); set_req(2, 0, 2'd3, 2'd1);
    cycle();
    check("R8 phy2 error", 32'(rc_s[0]), 32'h2);
    check("R8 chan1 error", 32'(rc_s[1]), 32'h2);
    check("R8 chan3 error", 32'(rc_s[2]), 32'h2);
    check("R8 sel unchanged", sel_s, 32'h8000_0010);

    // R10 release then claim in one cycle, R5 phy0 clears bit 31
    set_req(0, 1, 2'd2, 2'd0); set_req(1, 0, 2'd2, 2'd0);
    cycle();
    check("R10 claim after release", 32'(rc_s[1]), 32'h0);
    check("R5 std chan2 phy0", sel_s, 32'h0000_0010);

    // R11 idle cycle
    cycle();
    check("R11 idle no response", 32'(rv_s), 32'h0);

    for (int k = 0; k < 600; k++) begin
      for (int i = 0; i < N; i++) begin
        v[i]  = ($urandom % 3) != 0;
        rl[i] = ($urandom % 4) == 0;
        c[i]  = 2'(($urandom % 5 == 0) ? $urandom : ($urandom % 2) * 2);
        p[i]  = 2'(($urandom % 6 == 0) ? 2 + ($urandom % 2) : $urandom % 2);
      end
      cycle();
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule